// File: doc/BRIEF.md
# Accumulating Time-Interval Counter

This block measures how long it takes from a start event (for example a transmitted pulse) to a stop event (the matching received pulse) with a resolution finer than one reference clock period. It does this by repeating the measurement many times. Each time, it counts the reference clocks during which the interval is open and adds them to a single running total. The total is never cleared between intervals. The start and stop pulses arrive at random phases relative to the clock, so the rounding error of each single count differs from run to run. Over a long series these errors average out.

Both pulse inputs are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector. A series ends when a set number of intervals has closed. At that point a done flag rises and the outputs hold their values until the next arm command. An interval that never sees its stop is closed after a bounded number of clocks, and a sticky flag records that this happened. Converting the total into a distance, dividing it down to an average, and any analog front end are left to the logic around the block.

Top module: `interval_accumulator`

## Requirements
- R1: Each of `start_i` and `stop_i` is sampled by two flops, and only a low-to-high transition forms an event. A level held high produces exactly one event. A rise on `stop_i` that comes D clock cycles after a rise on `start_i` adds D to the total.
- R2: While an interval is open, `acc_o` grows by one for every clock cycle. The total is kept from one interval to the next, so after several intervals `acc_o` equals the sum of their lengths.
- R3: A start event that arrives while an interval is already open has no effect on the interval length or on the total.
- R4: A stop event that arrives while no interval is open leaves `acc_o` and `runs_o` unchanged.
- R5: `runs_o` goes up by one each time an interval closes. `done_o` rises when `runs_o` reaches REPEAT and stays low before that.
- R6: While `done_o` is high, start and stop events are ignored, and `acc_o` and `runs_o` do not change until the next arm command.
- R7: If no stop event arrives within TIMEOUT open cycles, the interval closes with exactly TIMEOUT added to the total. That interval counts as completed, and `timeout_o` is set and stays set until the next arm command. If a stop event lands on the TIMEOUT-th cycle, it closes the interval normally and does not set the flag.
- R8: Reset and `arm_i` both put the block into the same state: `acc_o`, `runs_o`, `done_o` and `timeout_o` at zero, and any open interval discarded. A later stop event then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Synchronous command: clear all results and start a new series |
| start_i | input | 1 | Asynchronous start pulse (transmit event) |
| stop_i | input | 1 | Asynchronous stop pulse (receive event) |
| acc_o | output | AW | Running sum of open-interval clock counts |
| runs_o | output | RW | Number of intervals closed in this series |
| done_o | output | 1 | Series complete (REPEAT intervals closed) |
| timeout_o | output | 1 | Sticky flag: at least one interval closed by timeout |

## Verification
An input that rises just after a falling clock edge becomes an event two rising edges later, and the registered outputs reflect that event one rising edge after that. A rise on `arm_i` takes effect at the very next rising edge. The bench drives every input on falling edges. After releasing a stop pulse, it waits four falling edges before it samples, so each interval has fully settled before any compare. It sweeps every interval length from 1 to beyond the timeout in series of REPEAT. For each length it computes the expected total as the running sum of min(D, TIMEOUT) and the expected flags from the length alone.

// File: rtl/iacc_pkg.sv
`timescale 1ns/1ps
package iacc_pkg;
  // One-step increment that holds at the ceiling instead of wrapping.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // Width needed to hold the value n.
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/iacc_sync.sv
`timescale 1ns/1ps
module iacc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic ev_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], async_i};
  end

  assign ev_o = sh_q[1] & ~sh_q[2];

  // R1: an event lasts exactly one cycle
  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o |=> !ev_o);
endmodule

// File: rtl/iacc_gate.sv
`timescale 1ns/1ps
module iacc_gate #(
  parameter int REPEAT  = 100,
  parameter int TIMEOUT = 4096,
  parameter int RW      = 7,
  parameter int TW      = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          start_ev,
  input  logic          stop_ev,
  output logic          open_o,
  output logic          close_o,
  output logic [RW-1:0] runs_o,
  output logic          done_o,
  output logic          timeout_o
);
  logic          open_q, done_q, to_q;
  logic [RW-1:0] runs_q;
  logic [TW-1:0] tcnt_q;
  logic          take_start, take_stop, expire;

  assign take_start = start_ev & ~open_q & ~done_q;
  assign take_stop  = stop_ev & open_q;
  assign expire     = open_q & ~stop_ev & (tcnt_q == TW'(TIMEOUT - 1));
  assign close_o    = take_stop | expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0;
      runs_q <= '0;   tcnt_q <= '0;
    end else if (arm) begin
      open_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0;
      runs_q <= '0;   tcnt_q <= '0;
    end else if (take_start) begin
      open_q <= 1'b1;
      tcnt_q <= '0;
    end else if (open_q) begin
      if (close_o) begin
        open_q <= 1'b0;
        runs_q <= runs_q + 1'b1;
        if (runs_q == RW'(REPEAT - 1)) done_q <= 1'b1;
        if (expire) to_q <= 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign open_o    = open_q;
  assign runs_o    = runs_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;

  // R4: stop with no open interval leaves the run count alone
  a_r4_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && stop_ev && !arm) |=> $stable(runs_q));
  // R3: a start while open neither closes nor restarts the interval
  a_r3_start_open: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && start_ev && !stop_ev && !expire && !arm) |=> (open_q && tcnt_q == $past(tcnt_q) + 1'b1));
  // R5: run count never passes the repeat count
  a_r5_runs_bound: assert property (@(posedge clk) disable iff (!rst_n)
    runs_q <= RW'(REPEAT));
  // R7: timeout flag only rises when an open interval closes
  a_r7_to_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> (!open_q && $past(open_q)));
  // R8: arm leaves a cleared state
  a_r8_arm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (runs_q == '0 && !done_q && !open_q && !to_q));
endmodule

// File: rtl/iacc_sum.sv
`timescale 1ns/1ps
module iacc_sum #(
  parameter int AW  = 19,
  parameter int LIM = 409600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          inc,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (arm) acc_q <= '0;
    else if (inc) acc_q <= AW'(iacc_pkg::sat_inc(32'(acc_q), 32'(LIM)));
  end

  assign acc_o = acc_q;

  // R2: total only ever steps by zero or one outside an arm
  a_r2_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (acc_q == $past(acc_q) || acc_q == $past(acc_q) + 1'b1));
  // R7: total stays within REPEAT*TIMEOUT
  a_r7_acc_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= AW'(LIM));
endmodule

// File: rtl/interval_accumulator.sv
`timescale 1ns/1ps
module interval_accumulator #(
  parameter int  REPEAT  = 100,
  parameter int  TIMEOUT = 4096,
  localparam int LIM     = REPEAT * TIMEOUT,
  localparam int AW      = iacc_pkg::width_for(LIM),
  localparam int RW      = iacc_pkg::width_for(REPEAT),
  localparam int TW      = iacc_pkg::width_for(TIMEOUT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic [AW-1:0] acc_o,
  output logic [RW-1:0] runs_o,
  output logic          done_o,
  output logic          timeout_o
);
  logic [1:0] raw, ev;
  logic       start_ev, stop_ev, gate_open, gate_close;

  assign raw = {stop_i, start_i};

  for (genvar c = 0; c < 2; c++) begin : g_sync
    iacc_sync u_sync (.clk(clk), .rst_n(rst_n), .async_i(raw[c]), .ev_o(ev[c]));
  end

  assign start_ev = ev[0];
  assign stop_ev  = ev[1];

  iacc_gate #(.REPEAT(REPEAT), .TIMEOUT(TIMEOUT), .RW(RW), .TW(TW)) u_gate (
    .clk(clk), .rst_n(rst_n), .arm(arm_i),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .open_o(gate_open), .close_o(gate_close),
    .runs_o(runs_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  iacc_sum #(.AW(AW), .LIM(LIM)) u_sum (
    .clk(clk), .rst_n(rst_n), .arm(arm_i), .inc(gate_open), .acc_o(acc_o)
  );

  // R6: a finished series is frozen until armed again
  a_r6_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> ($stable(acc_o) && $stable(runs_o) && !gate_open));
  // R5: every close advances the run count by one
  a_r5_close_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_close && !arm_i) |=> (runs_o == $past(runs_o) + 1'b1));
endmodule

// File: tb/interval_accumulator_test.sv
`timescale 1ns/1ps
module interval_accumulator_test;
  localparam int REP = 4;
  localparam int TO  = 20;

  logic       clk = 1'b0, rst_n = 1'b0, arm_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [6:0] acc_o;
  logic [2:0] runs_o;
  logic       done_o, timeout_o;
  int         checks = 0, failures = 0;
  int         exp_acc = 0, exp_runs = 0, exp_to = 0;

  always #2 clk = ~clk;

  interval_accumulator #(.REPEAT(REP), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .start_i(start_i), .stop_i(stop_i),
    .acc_o(acc_o), .runs_o(runs_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    arm_i = 1'b1; tick(1); arm_i = 1'b0; tick(1);
  endtask

  task automatic stop_pulse();
    stop_i = 1'b1; tick(2); stop_i = 1'b0; tick(4);
  endtask

  // start rises now, stop rises d cycles later
  task automatic interval(input int d);
    start_i = 1'b1;
    for (int k = 1; k <= d; k++) begin
      tick(1);
      if (k == 1) start_i = 1'b0;
    end
    stop_pulse();
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " acc"}, int'(acc_o), exp_acc);
    chk({tag, " runs"}, int'(runs_o), exp_runs);
    chk({tag, " done"}, int'(done_o), (exp_runs == REP) ? 1 : 0);
    chk({tag, " timeout"}, int'(timeout_o), exp_to);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    chk_all("R8 reset");

    // R2/R5: series of four, total kept across intervals
    begin
      int lens [4] = '{1, 3, 7, 12};
      foreach (lens[i]) begin
        interval(lens[i]);
        exp_acc += lens[i]; exp_runs++;
        chk_all("R2 R5 series");
      end
    end

    // R6: after done, a further interval changes nothing
    interval(5);
    chk_all("R6 frozen");

    do_arm();
    exp_acc = 0; exp_runs = 0; exp_to = 0;
    chk_all("R8 arm");

    // R4: stop with no interval open
    stop_pulse();
    chk_all("R4 idle stop");

    // R3: second start rise at cycle 3 ignored, stop at cycle 8
    start_i = 1'b1; tick(1); start_i = 1'b0; tick(2);
    start_i = 1'b1; tick(1); start_i = 1'b0; tick(4);
    stop_pulse();
    exp_acc += 8; exp_runs++;
    chk_all("R3 extra start");

    // R1: levels held high give one event each
    start_i = 1'b1; tick(6); stop_i = 1'b1; tick(12);
    exp_acc += 6; exp_runs++;
    chk_all("R1 held levels");
    start_i = 1'b0; stop_i = 1'b0; tick(4);
    chk_all("R1 release");

    // R7: no stop at all
    start_i = 1'b1; tick(1); start_i = 1'b0; tick(30);
    exp_acc += TO; exp_runs++; exp_to = 1;
    chk_all("R7 timeout");
    stop_pulse();
    chk_all("R4 late stop");

    // R8: arm in mid-interval discards it
    do_arm();
    exp_acc = 0; exp_runs = 0; exp_to = 0;
    start_i = 1'b1; tick(1); start_i = 1'b0; tick(5);
    do_arm();
    chk_all("R8 mid arm");
    stop_pulse();
    chk_all("R8 stop after abort");

    // R2/R5/R7 sweep of every length, series of REP
    do_arm();
    for (int d = 1; d <= TO + 4; d++) begin
      interval(d);
      exp_acc += (d > TO) ? TO : d;
      exp_runs++;
      if (d > TO) exp_to = 1;
      chk_all("R2 R5 R7 sweep");
      if (exp_runs == REP) begin
        do_arm();
        exp_acc = 0; exp_runs = 0; exp_to = 0;
        chk_all("R8 sweep arm");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule